// File: doc/BRIEF.md
# Address-Filtering Serial Receiver

This block receives asynchronous serial frames on a single line and can tag each frame with an extra address bit. The address bit follows the data bits, which lets several receivers share one line. A sender marks the frames that carry a station address with that bit set to 1, and the frames that carry payload with it set to 0. A receiver that does not want the current payload arms its filter. While the filter is armed, the receiver throws away every payload frame without touching its flags. It takes in the next address frame, and the filter then disarms itself.

The line is sampled against a 16x oversampling tick that comes from outside the block. Software reaches the block through a small register port. The port holds a control register, a status register and the receive data register. Two level interrupt requests are driven out: one for received data and one for receive errors.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset the control register (address 0) and the status register (address 1) both read 0, and both interrupt outputs are low.
- R2: Frames without an address bit (control bit 1 = 0) have this layout: one low start bit, 8 data bits with the LSB first, then one stop bit. A received frame is stored in the data register (address 2). It sets the data-full flag (status bit 0). While data-full is set and the receive interrupt enable (control bit 3) is 1, `irq_rx_o` is high.
- R3: A read of address 2 returns the stored byte and clears data-full.
- R4: A stop bit sampled low sets the framing-error flag (status bit 2). The byte is still stored. While an error flag is set and the error interrupt enable (control bit 4) is 1, `irq_err_o` is high.
- R5: If an accepted frame completes while data-full is set, the overrun flag (status bit 1) is set and the data register keeps its previous byte.
- R6: Writing 0 to bit 2 or bit 1 of address 1 clears that error flag. Writing 1 to either bit leaves it unchanged.
- R7: With control bit 1 = 1, each frame carries its address bit between the last data bit and the stop bit. An accepted frame copies that bit to status bit 3.
- R8: With the filter enable (control bit 2) set, control bit 1 = 1 and control bit 0 = 0, a frame whose address bit is 0 is discarded. The data register, data-full, both error flags and status bit 3 stay unchanged, even when the stop bit is low or data-full was already set.
- R9: Under the conditions of R8, a frame whose address bit is 1 is accepted normally. Status bit 3 becomes 1 and control bit 2 clears by itself. Frames after it are accepted normally.
- R10: The filter enable has no effect when control bit 0 (synchronous mode select) is 1, or when control bit 1 is 0.
- R11: While the filter is in effect, both interrupt outputs stay low, whatever the flags hold.
- R12: A start bit that is no longer low at its middle sample is rejected. No frame is received from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd_i | input | 1 | Serial receive line, idle high |
| os_tick_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address: 0 control, 1 status, 2 data |
| reg_wdata_i | input | 5 | Register write data |
| reg_rdata_o | output | 8 | Read data, valid in the cycle after the read strobe |
| irq_rx_o | output | 1 | Receive-data interrupt request |
| irq_err_o | output | 1 | Receive-error interrupt request |

## Verification
The stop bit is sampled at its middle tick. The flags, the data register and the self-clearing filter bit change on the clock edge after that sample. The interrupt outputs follow one edge later, and read data appears one edge after the read strobe. The bench holds every stop bit for its full 64-cycle bit time and then idles the line before it looks at anything. It reads registers at the falling edge after the strobe has been registered, and it samples interrupts at a falling edge at least two cycles after the flag or control change that drives them. A low stop bit is held only a little past its middle sample, so that the receiver does not take the low tail as a new start bit.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

  localparam int CTRL_W = 5;

  // Control register fields, LSB first: sync_mode (bit 0), mp_fmt (bit 1),
  // filt (bit 2), rie (bit 3), eie (bit 4).
  typedef struct packed {
    logic eie;
    logic rie;
    logic filt;
    logic mp_fmt;
    logic sync_mode;
  } ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_BITS  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_t;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

endpackage

// File: rtl/mpu_rx_sync.sv
module mpu_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '1;
    else     chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mpu_rx_frame.sv
module mpu_rx_frame
  import mpu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OS_RATE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic              mp_fmt_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              mp_o,
  output logic              stop_ok_o
);
  localparam int CNT_W = $clog2(OS_RATE);
  localparam int BC_W  = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OS_RATE / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OS_RATE - 1);

  rx_state_t         state_q;
  logic [CNT_W-1:0]  tcnt_q;
  logic [BC_W-1:0]   bcnt_q;
  logic [DATA_W:0]   shreg_q;
  logic              fmt_q;
  logic [BC_W-1:0]   last_bit;

  // The frame is one bit longer when it carries the address bit.
  assign last_bit = fmt_q ? BC_W'(DATA_W) : BC_W'(DATA_W - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      tcnt_q    <= '0;
      bcnt_q    <= '0;
      shreg_q   <= '0;
      fmt_q     <= 1'b0;
      done_o    <= 1'b0;
      data_o    <= '0;
      mp_o      <= 1'b0;
      stop_ok_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (!rx_i) begin
            state_q <= ST_START;
            tcnt_q  <= '0;
            fmt_q   <= mp_fmt_i;
          end
        end
        ST_START: begin
          if (tick_i) begin
            if (tcnt_q == MID) begin
              tcnt_q <= '0;
              bcnt_q <= '0;
              state_q <= rx_i ? ST_IDLE : ST_BITS;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
        end
        ST_BITS: begin
          if (tick_i) begin
            if (tcnt_q == LAST) begin
              tcnt_q  <= '0;
              shreg_q <= {rx_i, shreg_q[DATA_W:1]};
              if (bcnt_q == last_bit) state_q <= ST_STOP;
              else                    bcnt_q  <= bcnt_q + 1'b1;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
        end
        ST_STOP: begin
          if (tick_i) begin
            if (tcnt_q == LAST) begin
              tcnt_q    <= '0;
              state_q   <= ST_IDLE;
              done_o    <= 1'b1;
              stop_ok_o <= rx_i;
              data_o    <= fmt_q ? shreg_q[DATA_W-1:0] : shreg_q[DATA_W:1];
              mp_o      <= fmt_q ? shreg_q[DATA_W] : 1'b0;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // A start bit that is high again at its middle sample drops back to idle.
  property p_glitch;
    @(posedge clk) disable iff (rst)
      (state_q == ST_START && tick_i && tcnt_q == MID && rx_i) |=> (state_q == ST_IDLE);
  endproperty
  assert_glitch_reject_R12: assert property (p_glitch);

  // A completed frame is reported only on the edge that leaves the stop state.
  property p_done_from_stop;
    @(posedge clk) disable iff (rst)
      done_o |-> (state_q == ST_IDLE && $past(state_q) == ST_STOP);
  endproperty
  assert_done_after_stop_R2: assert property (p_done_from_stop);
endmodule

// File: rtl/mpu_rx_regs.sv
module mpu_rx_regs
  import mpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              mp_i,
  input  logic              stop_ok_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [CTRL_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_rx_o,
  output logic              irq_err_o,
  output logic              mp_fmt_o
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] data_q;
  logic              full_q, ferr_q, ovr_q, mpb_q;
  logic              filt_eff, drop, accept, rd_data, full_eff, wr_stat, wr_ctrl;

  // The filter acts only in asynchronous mode with the address-bit format on.
  assign filt_eff = ctrl_q.filt & ~ctrl_q.sync_mode & ctrl_q.mp_fmt;
  assign drop     = done_i & filt_eff & ~mp_i;
  assign accept   = done_i & ~drop;
  assign rd_data  = reg_rd_i && (reg_addr_i == A_DATA);
  assign wr_stat  = reg_wr_i && (reg_addr_i == A_STAT);
  assign wr_ctrl  = reg_wr_i && (reg_addr_i == A_CTRL);
  assign full_eff = full_q & ~rd_data;
  assign mp_fmt_o = ctrl_q.mp_fmt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata_i);
      if (done_i && filt_eff && mp_i) ctrl_q.filt <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      full_q <= 1'b0;
      ferr_q <= 1'b0;
      ovr_q  <= 1'b0;
      mpb_q  <= 1'b0;
    end else begin
      if (rd_data) full_q <= 1'b0;
      if (wr_stat) begin
        ferr_q <= ferr_q & reg_wdata_i[2];
        ovr_q  <= ovr_q  & reg_wdata_i[1];
      end
      if (accept) begin
        if (full_eff) begin
          ovr_q <= 1'b1;
        end else begin
          data_q <= data_i;
          full_q <= 1'b1;
        end
        if (!stop_ok_i)     ferr_q <= 1'b1;
        if (ctrl_q.mp_fmt)  mpb_q  <= mp_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata_o <= '0;
      irq_rx_o    <= 1'b0;
      irq_err_o   <= 1'b0;
    end else begin
      if (reg_rd_i) begin
        unique case (reg_addr_i)
          A_CTRL:  reg_rdata_o <= {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
          A_STAT:  reg_rdata_o <= {{(DATA_W-4){1'b0}}, mpb_q, ferr_q, ovr_q, full_q};
          A_DATA:  reg_rdata_o <= data_q;
          default: reg_rdata_o <= '0;
        endcase
      end
      irq_rx_o  <= full_q & ctrl_q.rie & ~filt_eff;
      irq_err_o <= (ferr_q | ovr_q) & ctrl_q.eie & ~filt_eff;
    end
  end

  property p_drop_hold;
    @(posedge clk) disable iff (rst)
      (done_i && filt_eff && !mp_i) |=> ($stable(data_q) && $stable(mpb_q));
  endproperty
  assert_filtered_frame_hold_R8: assert property (p_drop_hold);

  property p_disarm;
    @(posedge clk) disable iff (rst)
      (done_i && filt_eff && mp_i) |=> (!ctrl_q.filt && mpb_q);
  endproperty
  assert_addr_frame_disarms_R9: assert property (p_disarm);

  property p_ovr_hold;
    @(posedge clk) disable iff (rst)
      (accept && full_q && !rd_data) |=> ($stable(data_q) && ovr_q);
  endproperty
  assert_overrun_keeps_data_R5: assert property (p_ovr_hold);

  property p_irq_quiet;
    @(posedge clk) disable iff (rst)
      (irq_rx_o || irq_err_o) |-> !$past(filt_eff);
  endproperty
  assert_irq_quiet_filter_R11: assert property (p_irq_quiet);
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
  import mpu_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxd_i,
  input  logic              os_tick_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [CTRL_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_rx_o,
  output logic              irq_err_o
);
  logic              rx_s, done, mp, stop_ok, mp_fmt;
  logic [DATA_W-1:0] fdata;

  mpu_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d_i(rxd_i), .q_o(rx_s)
  );

  mpu_rx_frame #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) frame_i (
    .clk(clk), .rst(rst), .rx_i(rx_s), .tick_i(os_tick_i), .mp_fmt_i(mp_fmt),
    .done_o(done), .data_o(fdata), .mp_o(mp), .stop_ok_o(stop_ok)
  );

  mpu_rx_regs #(.DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst(rst), .done_i(done), .data_i(fdata), .mp_i(mp),
    .stop_ok_i(stop_ok), .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_rx_o(irq_rx_o), .irq_err_o(irq_err_o),
    .mp_fmt_o(mp_fmt)
  );
endmodule

// File: tb/mp_uart_rx_tb_top.sv
module mp_uart_rx_tb_top;
  localparam int BIT_CLKS = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxd = 1'b1;
  logic       os_tick = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [4:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_rx, irq_err;
  int         n_cmp = 0;
  int         n_bad = 0;
  int         cyc = 0;
  bit         done_run = 1'b0;
  logic [1:0] tdiv = '0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc  <= cyc + 1;
    tdiv <= tdiv + 1'b1;
    os_tick <= (tdiv == 2'd3);
  end

  mp_uart_rx dut_i (
    .clk(clk), .rst(rst), .rxd_i(rxd), .os_tick_i(os_tick),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_rx_o(irq_rx), .irq_err_o(irq_err)
  );

  task automatic cmp(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [4:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic hold(input logic v, input int n);
    @(negedge clk); rxd = v;
    repeat (n - 1) @(negedge clk);
  endtask

  // with_mp adds the address bit; a low stop bit is kept short so its tail
  // is not taken for a new start bit
  task automatic send(input logic [7:0] d, input logic with_mp, input logic mpb,
                      input logic stop);
    hold(1'b0, BIT_CLKS);
    for (int i = 0; i < 8; i++) hold(d[i], BIT_CLKS);
    if (with_mp) hold(mpb, BIT_CLKS);
    if (stop) hold(1'b1, BIT_CLKS);
    else begin hold(1'b0, 44); hold(1'b1, BIT_CLKS); end
    hold(1'b1, 16);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(2'd0, v); cmp("R1 ctrl after reset", v, 8'h00);
    rd(2'd1, v); cmp("R1 status after reset", v, 8'h00);
    cmp("R1 irq lines after reset", {6'd0, irq_rx, irq_err}, 8'h00);
  endtask

  task automatic t_plain;
    logic [7:0] v;
    wr(2'd0, 5'h08);
    send(8'hA5, 1'b0, 1'b0, 1'b1);
    rd(2'd1, v); cmp("R2 status after frame", v, 8'h01);
    cmp("R2 irq_rx with rie", {7'd0, irq_rx}, 8'h01);
    rd(2'd2, v); cmp("R3 data read", v, 8'hA5);
    repeat (3) @(negedge clk);
    rd(2'd1, v); cmp("R3 full cleared by read", v, 8'h00);
    cmp("R3 irq_rx drops", {7'd0, irq_rx}, 8'h00);
  endtask

  task automatic t_ferr;
    logic [7:0] v;
    wr(2'd0, 5'h10);
    send(8'h3C, 1'b0, 1'b0, 1'b0);
    rd(2'd1, v); cmp("R4 framing error flag", v, 8'h05);
    cmp("R4 irq_err", {7'd0, irq_err}, 8'h01);
    rd(2'd2, v); cmp("R4 byte still stored", v, 8'h3C);
    wr(2'd1, 5'h1F);
    rd(2'd1, v); cmp("R6 write 1 keeps flag", v, 8'h04);
    wr(2'd1, 5'h00);
    rd(2'd1, v); cmp("R6 write 0 clears flag", v, 8'h00);
    repeat (2) @(negedge clk);
    cmp("R6 irq_err cleared", {7'd0, irq_err}, 8'h00);
  endtask

  task automatic t_ovr;
    logic [7:0] v;
    wr(2'd0, 5'h00);
    send(8'h11, 1'b0, 1'b0, 1'b1);
    send(8'h22, 1'b0, 1'b0, 1'b1);
    rd(2'd1, v); cmp("R5 overrun flag", v, 8'h03);
    rd(2'd2, v); cmp("R5 old byte kept", v, 8'h11);
    wr(2'd1, 5'h00);
    rd(2'd1, v); cmp("R5 cleanup status", v, 8'h00);
  endtask

  task automatic t_mpb;
    logic [7:0] v;
    wr(2'd0, 5'h02);
    send(8'h44, 1'b1, 1'b1, 1'b1);
    rd(2'd1, v); cmp("R7 address bit 1 stored", v, 8'h09);
    rd(2'd2, v); cmp("R7 data with address bit", v, 8'h44);
    send(8'h55, 1'b1, 1'b0, 1'b1);
    rd(2'd1, v); cmp("R7 address bit 0 stored", v, 8'h01);
    rd(2'd2, v); cmp("R7 data second frame", v, 8'h55);
  endtask

  task automatic t_filter;
    logic [7:0] v;
    wr(2'd0, 5'h1E);
    send(8'h10, 1'b1, 1'b0, 1'b1);
    send(8'h20, 1'b1, 1'b0, 1'b0);
    send(8'h30, 1'b1, 1'b0, 1'b1);
    rd(2'd1, v); cmp("R8 flags untouched by filtered frames", v, 8'h00);
    cmp("R8 irqs quiet", {6'd0, irq_rx, irq_err}, 8'h00);
    rd(2'd0, v); cmp("R8 filter still armed", v, 8'h1E);
    rd(2'd2, v); cmp("R8 data register unchanged", v, 8'h55);
    send(8'h7E, 1'b1, 1'b1, 1'b1);
    rd(2'd0, v); cmp("R9 filter bit self-cleared", v, 8'h1A);
    rd(2'd1, v); cmp("R9 address frame accepted", v, 8'h09);
    cmp("R9 irq_rx after address frame", {7'd0, irq_rx}, 8'h01);
    rd(2'd2, v); cmp("R9 address frame data", v, 8'h7E);
    send(8'h40, 1'b1, 1'b0, 1'b1);
    rd(2'd1, v); cmp("R9 later payload accepted", v, 8'h01);
    rd(2'd2, v); cmp("R9 later payload data", v, 8'h40);
  endtask

  task automatic t_irqgate;
    logic [7:0] v;
    wr(2'd0, 5'h0A);
    send(8'h61, 1'b1, 1'b1, 1'b1);
    cmp("R11 irq_rx before arming", {7'd0, irq_rx}, 8'h01);
    wr(2'd0, 5'h0E);
    repeat (2) @(negedge clk);
    cmp("R11 irq_rx masked while armed", {7'd0, irq_rx}, 8'h00);
    send(8'h62, 1'b1, 1'b0, 1'b1);
    rd(2'd1, v); cmp("R8 no overrun from filtered frame", v, 8'h09);
    send(8'h63, 1'b1, 1'b1, 1'b1);
    rd(2'd1, v); cmp("R9 address frame overruns", v, 8'h0B);
    rd(2'd2, v); cmp("R9 overrun keeps old byte", v, 8'h61);
    wr(2'd1, 5'h00);
  endtask

  task automatic t_ignore;
    logic [7:0] v;
    wr(2'd0, 5'h07);
    send(8'h81, 1'b1, 1'b0, 1'b1);
    rd(2'd1, v); cmp("R10 sync mode ignores filter", v, 8'h01);
    rd(2'd0, v); cmp("R10 filter bit unchanged", v, 8'h07);
    rd(2'd2, v); cmp("R10 data in sync-mode case", v, 8'h81);
    wr(2'd0, 5'h04);
    send(8'h82, 1'b0, 1'b0, 1'b1);
    rd(2'd1, v); cmp("R10 no-format ignores filter", v, 8'h01);
    rd(2'd2, v); cmp("R10 data in no-format case", v, 8'h82);
    wr(2'd0, 5'h00);
  endtask

  task automatic t_glitch;
    logic [7:0] v;
    hold(1'b0, 12);
    hold(1'b1, 200);
    rd(2'd1, v); cmp("R12 glitch gives no frame", v, 8'h00);
    send(8'h5A, 1'b0, 1'b0, 1'b1);
    rd(2'd2, v); cmp("R12 next frame intact", v, 8'h5A);
  endtask

  task automatic finish_run;
    if (!done_run) begin
      done_run = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_plain();
    t_ferr();
    t_ovr();
    t_mpb();
    t_filter();
    t_irqgate();
    t_ignore();
    t_glitch();
    finish_run();
  end

  initial begin
    wait (cyc > 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    finish_run();
  end
endmodule